// File: doc/BRIEF.md
# Digital Power-On Clock and Receiver Enable Manager

This block decides when the digital part of a readout chip may draw power. Two requests keep it awake. The data-acquisition system raises one during acquisition and conversion. The chip raises the other for its own readout, and that request starts when the previous chip in the chain sends a start-readout pulse. The effective power-on is the OR of the two.

Either request wakes the block at once, with no clock edge needed. The differential receivers are enabled at that moment. The clock enables follow at the next low phase of the clock, so that the gated clock starts cleanly. When a request is withdrawn, its release passes through a two-stage synchroniser on the slow clock. Once nothing holds power-on, the receiver enables and the clock enables drop together on one falling clock edge. Each enable is driven as two identical copies. A one-cycle internal start-readout strobe launches the chip's readout sequencer. A done pulse from that sequencer ends the readout request.

Top module: `pwr_on_mgr`

## Requirements
- R1: `pwr_on_o` is high exactly when the acquisition hold or the readout hold is active. The acquisition hold is `daq_req_i` OR its synchronised copy. The readout hold is `sro_i` OR the registered readout flag.
- R2: A high level on `daq_req_i` drives `pwr_on_o` and both `lvds_en_o` bits high combinationally, before any clock edge.
- R3: After `daq_req_i` falls, the acquisition hold stays active through the first rising `clk` edge. It ends on the second rising edge (SYNC_STAGES = 2).
- R4: `sro_i` must be held high for at least 3 rising edges. Its rise yields `sro_int_o` high for exactly one cycle: the cycle after the second rising edge that samples `sro_i` high.
- R5: The readout flag is set on the rising edge that ends the strobe cycle. It is cleared on a later rising edge that samples `ro_done_i` high. When the set and the clear meet on the same edge, the set wins. `pwr_on_o` stays high after `sro_i` falls, until the flag clears.
- R6: `clk_en_o` changes only on a falling `clk` edge. It takes the value `pwr_on_o` has at that edge.
- R7: `lvds_en_o` equals `daq_req_i` OR `sro_i` OR the clock-run state. When power-on is released, the receiver enables and the clock enables fall on the same falling edge.
- R8: The two bits of `lvds_en_o` are always equal. The two bits of `clk_en_o` are always equal.
- R9: While `rst_n` is low and the request inputs are low, every output is 0. Internal registers leave reset two rising edges after `rst_n` rises.
- R10: A `ro_done_i` pulse while no readout is active leaves `pwr_on_o` and all enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| daq_req_i | input | 1 | Acquisition/conversion power request, level |
| sro_i | input | 1 | Start-readout pulse from the previous chip |
| ro_done_i | input | 1 | End-of-readout pulse from the local sequencer |
| pwr_on_o | output | 1 | Effective internal power-on |
| lvds_en_o | output | 2 | Receiver enables, duplicated |
| clk_en_o | output | 2 | Clock enables, duplicated, change on falling edge |
| sro_int_o | output | 1 | One-cycle internal start-readout strobe |

## Verification
A stuck or badly timed release stage shows at `pwr_on_o` on the second rising edge after `daq_req_i` falls, or after the done pulse. Half a cycle later it shows at the clock enables. A fault in the start-readout synchroniser shifts or widens `sro_int_o` by whole cycles. It can also leave power-on held or dropped once the incoming pulse ends. The bench compares every output against a behavioural model once per cycle, in the low phase of the clock, after the falling-edge register has settled. Any of these errors is therefore reported within one cycle of the moment it first reaches a port.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;
  // synchroniser depth used for request release and start-readout capture
  parameter int unsigned SYNC_STAGES = 2;
  // number of identical copies of each enable
  parameter int unsigned EN_COPIES   = 2;
endpackage

// File: rtl/pwr_rst_sync.sv
module pwr_rst_sync #(
  parameter int unsigned STAGES = pwr_gate_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/pwr_daq_hold.sv
module pwr_daq_hold #(
  parameter int unsigned STAGES = pwr_gate_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic hold_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], req_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // set follows the input at once; release waits for every stage to clear
  assign hold_o = req_i | (|sh_q);
endmodule

// File: rtl/pwr_ro_ctrl.sv
module pwr_ro_ctrl #(
  parameter int unsigned STAGES = pwr_gate_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sro_i,
  input  logic done_i,
  output logic strobe_o,
  output logic hold_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] cap_q;
  logic [DEPTH-1:0] cap_d;
  logic             busy_q;
  logic             busy_d;
  logic             strobe;

  always_comb begin
    cap_d  = {cap_q[DEPTH-2:0], sro_i};
    strobe = cap_q[STAGES-1] & ~cap_q[STAGES];
    busy_d = strobe | (busy_q & ~done_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      busy_q <= busy_d;
    end
  end

  assign strobe_o = strobe;
  assign hold_o   = sro_i | busy_q;
endmodule

// File: rtl/pwr_on_mgr.sv
module pwr_on_mgr
  import pwr_gate_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES,
  parameter int unsigned COPIES = EN_COPIES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              daq_req_i,
  input  logic              sro_i,
  input  logic              ro_done_i,
  output logic              pwr_on_o,
  output logic [COPIES-1:0] lvds_en_o,
  output logic [COPIES-1:0] clk_en_o,
  output logic              sro_int_o
);
  logic rst_sync_n;
  logic daq_hold;
  logic ro_hold;
  logic pwr_req;
  logic run_q;
  logic run_d;
  logic raw_wake;

  pwr_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  pwr_daq_hold #(.STAGES(STAGES)) u_daq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .req_i (daq_req_i),
    .hold_o(daq_hold)
  );

  pwr_ro_ctrl #(.STAGES(STAGES)) u_ro (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sro_i   (sro_i),
    .done_i  (ro_done_i),
    .strobe_o(sro_int_o),
    .hold_o  (ro_hold)
  );

  always_comb begin
    pwr_req  = daq_hold | ro_hold;
    raw_wake = daq_req_i | sro_i;
    run_d    = pwr_req;
  end

  // clock-run state updates while the gated clock is low
  always_ff @(negedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) run_q <= 1'b0;
    else             run_q <= run_d;
  end

  assign pwr_on_o = pwr_req;

  for (genvar g = 0; g < COPIES; g++) begin : g_en
    assign clk_en_o[g]  = run_q;
    assign lvds_en_o[g] = raw_wake | run_q;
  end
endmodule

// File: rtl/pwr_on_mgr_chk.sv
module pwr_on_mgr_chk #(
  parameter int unsigned COPIES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              daq_req_i,
  input logic              pwr_on_o,
  input logic [COPIES-1:0] lvds_en_o,
  input logic [COPIES-1:0] clk_en_o,
  input logic              sro_int_o
);
  // R2
  daq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    daq_req_i |-> (pwr_on_o && (&lvds_en_o)));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sro_int_o |=> !sro_int_o);

  // R5
  ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sro_int_o |=> pwr_on_o);

  // R7
  stop_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvds_en_o[0]) |-> $fell(clk_en_o[0]));

  // R8
  copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_en_o == '0) || (&clk_en_o)) && ((lvds_en_o == '0) || (&lvds_en_o)));
endmodule

bind pwr_on_mgr pwr_on_mgr_chk #(.COPIES(COPIES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .daq_req_i(daq_req_i),
  .pwr_on_o (pwr_on_o),
  .lvds_en_o(lvds_en_o),
  .clk_en_o (clk_en_o),
  .sro_int_o(sro_int_o)
);

// File: tb/tb_pwr_on_mgr.sv
`timescale 1ns/100ps
module tb_pwr_on_mgr;
  localparam int S = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       daq_req, sro, ro_done;
  logic       pwr_on, sro_int;
  logic [1:0] lvds_en, clk_en;

  int compared = 0;
  int mismatched = 0;
  bit running = 1'b0;

  pwr_on_mgr dut (
    .clk(clk), .rst_n(rst_n), .daq_req_i(daq_req), .sro_i(sro),
    .ro_done_i(ro_done), .pwr_on_o(pwr_on), .lvds_en_o(lvds_en),
    .clk_en_o(clk_en), .sro_int_o(sro_int)
  );

  always #2 clk = ~clk;

  // behavioural model
  int  m_cnt;
  bit  m_hist[$];
  bit  m_busy, m_run, m_strobe;

  function automatic bit m_daq();
    return daq_req || (m_cnt < S);
  endfunction
  function automatic bit m_pwr();
    return m_daq() || sro || m_busy;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = S; m_busy = 0; m_run = 0; m_strobe = 0;
      m_hist = {};
      for (int i = 0; i <= S; i++) m_hist.push_back(1'b0);
    end else begin
      if (m_strobe) m_busy = 1;
      else if (ro_done) m_busy = 0;
      m_cnt = daq_req ? 0 : ((m_cnt < S) ? m_cnt + 1 : S);
      m_hist.push_front(sro);
      void'(m_hist.pop_back());
      m_strobe = m_hist[S-1] && !m_hist[S];
    end
  end

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison in the low phase, after the falling-edge register
  always @(negedge clk) begin
    if (rst_n) m_run = m_pwr();
    #1;
    if (running && rst_n) begin
      chk("R1 pwr_on", {1'b0, pwr_on}, {1'b0, m_pwr()});
      chk("R6 R8 clk_en", clk_en, {2{m_run}});
      chk("R7 R8 lvds_en", lvds_en, {2{daq_req | sro | m_run}});
      chk("R4 sro_int", {1'b0, sro_int}, {1'b0, m_strobe});
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; daq_req = 0; sro = 0; ro_done = 0;
    step(3);
    // R9 reset state
    chk("R9 reset pwr_on", {1'b0, pwr_on}, 2'b00);
    chk("R9 reset enables", lvds_en | clk_en, 2'b00);
    chk("R9 reset strobe", {1'b0, sro_int}, 2'b00);
    rst_n = 1;
    step(4);
    running = 1;

    // R2 immediate set
    daq_req = 1; #0.5;
    chk("R2 pwr_on async", {1'b0, pwr_on}, 2'b01);
    chk("R2 lvds_en async", lvds_en, 2'b11);
    chk("R6 clk_en waits", clk_en, 2'b00);
    step(5);
    // R3 release on second edge
    daq_req = 0;
    step(1);
    chk("R3 held after edge 1", {1'b0, pwr_on}, 2'b01);
    step(1);
    chk("R3 released at edge 2", {1'b0, pwr_on}, 2'b00);
    chk("R6 clk_en before fall", clk_en, 2'b11);
    @(negedge clk); #0.5;
    chk("R6 clk_en after fall", clk_en, 2'b00);
    chk("R7 lvds_en falls together", lvds_en, 2'b00);
    step(3);

    // R10 done while idle
    ro_done = 1; step(1); ro_done = 0; step(2);
    chk("R10 idle done", {1'b0, pwr_on}, 2'b00);
    chk("R10 idle enables", lvds_en | clk_en, 2'b00);

    // R4/R5 readout
    sro = 1; step(4); sro = 0;
    step(6);
    chk("R5 readout held", {1'b0, pwr_on}, 2'b01);
    ro_done = 1; step(1); ro_done = 0;
    chk("R5 readout released", {1'b0, pwr_on}, 2'b00);
    step(4);

    // overlap of both requests
    daq_req = 1; step(2); sro = 1; step(3); sro = 0; step(2);
    daq_req = 0; step(4);
    chk("R1 readout keeps power", {1'b0, pwr_on}, 2'b01);
    ro_done = 1; step(1); ro_done = 0; step(4);

    // done held across strobe: set wins, cleared next edge
    ro_done = 1; sro = 1; step(3); sro = 0; step(3); ro_done = 0; step(4);
    chk("R5 set-wins then cleared", {1'b0, pwr_on}, 2'b00);

    // short daq pulse
    daq_req = 1; step(1); daq_req = 0; step(6);

    running = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule